// File: doc/BRIEF.md
# Byte-Stream SPI Command Engine

This block turns a stream of command bytes into activity on an SPI master port and a small bank of general-purpose pins. Bytes arrive over a valid/ready interface. Each opcode is either complete by itself or followed by argument bytes. The opcodes set the serial clock rate, switch a fixed divide-by-5 prescaler on or off, switch internal data loopback on or off, load the value and direction of the eight pins, or move a block of bytes over the serial link.

A pin write with bit 3 cleared or set selects or releases the slave device, so chip select has no opcode of its own. Block lengths are sent as a two-byte count of length minus one, low byte first, so one block holds from 1 to 65536 bytes. Bytes shifted in are returned on a valid/ready output stream. An opcode the engine does not know is answered on that same stream with an error pair, and decoding then starts again at the next byte.

Top module: `spi_byte_engine`

## Requirements
- R1: After reset `pin_out` and `pin_oe` are 0x00, `in_ready` is 1 and `out_valid` is 0. The prescaler is on, the divisor is 0 and loopback is off, so the first transfer runs with an SCK period of 10 clocks.
- R2: Opcode 0x80, then a value byte, then a direction byte, loads `pin_out` with the value and `pin_oe` with the direction. Bit 0 is SCK, bit 1 is MOSI, bit 2 is MISO (read from the `miso` input) and bit 3 is chip select. While a byte is being shifted, bits 0 and 1 of `pin_out` are driven by the engine.
- R3: Opcode 0x11 plus a count is followed by the data bytes. Each byte is shifted out MSB first in SPI mode 0: MOSI changes only while SCK falls, is valid before the first rising edge, and SCK rests low.
- R4: Opcode 0x20 plus a count shifts in bytes MSB first, sampling `miso` on each rising SCK edge. The bytes are delivered on `out_data` in the order received.
- R5: A count is two bytes, low then high, holding N-1 for an N-byte block. It covers 1 to 65536 bytes, and every block produces exactly 8·N SCK rising edges.
- R6: Opcode 0x86, then low and high divisor bytes D, sets each SCK half-period to (D+1)·P clocks, giving an SCK period of 2·(D+1)·P clocks. P is 5 after opcode 0x8B and 1 after opcode 0x8A.
- R7: After opcode 0x84 the read path samples the engine's own MOSI instead of `miso`. A read then returns 0x00, because reads shift out zeros. Opcode 0x85 restores sampling from `miso`.
- R8: Any other opcode yields the output bytes 0xFA and then that opcode. The engine then decodes the next input byte as a new opcode.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds and no further input is decoded. The engine accepts no input byte while a byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine clock, also the base of the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command or argument byte |
| in_ready | output | 1 | Engine takes `in_data` on this edge |
| out_valid | output | 1 | Returned byte present |
| out_data | output | 8 | Read data or error pair byte |
| out_ready | input | 1 | Consumer takes `out_data` |
| miso | input | 1 | Serial data from slave (pin bit 2), synchronous to `clk` |
| pin_out | output | 8 | Pin levels: SCK, MOSI, MISO slot, chip select, spare |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The hardest condition to reach from the ports is a long block whose high count byte is non-zero. Reaching it means keeping the engine busy for hundreds of bytes while a slave model on the pins counts every rising edge and rebuilds each byte. The bench turns the prescaler off so that a 257-byte block finishes in a few thousand cycles. It also loads a divisor with a non-zero high byte to exercise the divisor's upper half. Loopback is told apart from a real slave by making the slave model return a known non-zero pattern, so a loopback read that returns zeros can only come from the engine's own MOSI.

// File: rtl/spb_pkg.sv
package spb_pkg;
   localparam logic [7:0] OP_PINS     = 8'h80;
   localparam logic [7:0] OP_LOOP_ON  = 8'h84;
   localparam logic [7:0] OP_LOOP_OFF = 8'h85;
   localparam logic [7:0] OP_DIV      = 8'h86;
   localparam logic [7:0] OP_PRE_OFF  = 8'h8A;
   localparam logic [7:0] OP_PRE_ON   = 8'h8B;
   localparam logic [7:0] OP_WRITE    = 8'h11;
   localparam logic [7:0] OP_READ     = 8'h20;
   localparam logic [7:0] ERR_TAG     = 8'hFA;

   typedef enum logic [3:0] {
      S_IDLE, S_ARG_A, S_ARG_B, S_WR, S_WR_SH,
      S_RD, S_RD_SH, S_RD_PUSH, S_ERR_A, S_ERR_B
   } state_t;
endpackage

// File: rtl/spb_clkgen.sv
module spb_clkgen #(
   parameter int DIV_W    = 16,
   parameter int PRESCALE = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pre_en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int PC_W = $clog2(PRESCALE);

   logic [PC_W-1:0]  pc_q;
   logic [DIV_W-1:0] hc_q;
   logic             pre_tick;

   assign pre_tick = !pre_en || (pc_q == PC_W'(PRESCALE - 1));
   assign tick     = run && pre_tick && (hc_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
         hc_q <= '0;
      end else if (!run) begin
         pc_q <= '0;
         hc_q <= '0;
      end else begin
         if (!pre_en || pc_q == PC_W'(PRESCALE - 1)) pc_q <= '0;
         else                                         pc_q <= pc_q + 1'b1;
         if (pre_tick) hc_q <= (hc_q == div) ? '0 : hc_q + 1'b1;
      end
   end
endmodule

// File: rtl/spb_shifter.sv
module spb_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] tx,
   input  logic         tick,
   input  logic         miso,
   output logic         busy,
   output logic         sck,
   output logic         mosi,
   output logic         done,
   output logic [W-1:0] rx
);
   localparam int CNT_W = $clog2(W);

   logic [CNT_W-1:0] cnt_q;
   logic [W-1:0]     tx_sh, rx_sh;
   logic             busy_q, sck_q;

   assign busy = busy_q;
   assign sck  = sck_q;
   assign mosi = tx_sh[W-1];
   assign rx   = rx_sh;
   assign done = busy_q && tick && sck_q && (cnt_q == CNT_W'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         cnt_q  <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            tx_sh  <= tx;
            cnt_q  <= '0;
            sck_q  <= 1'b0;
         end
      end else if (tick) begin
         if (!sck_q) begin
            sck_q <= 1'b1;
            rx_sh <= {rx_sh[W-2:0], miso};
         end else begin
            sck_q <= 1'b0;
            tx_sh <= {tx_sh[W-2:0], 1'b0};
            if (cnt_q == CNT_W'(W - 1)) busy_q <= 1'b0;
            else                        cnt_q  <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
   parameter int DIV_W       = 16,
   parameter int PRESCALE    = 5,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output logic       in_ready,
   output logic       out_valid,
   output logic [7:0] out_data,
   input  logic       out_ready,
   input  logic       miso,
   output logic [7:0] pin_out,
   output logic [7:0] pin_oe
);
   import spb_pkg::*;

   localparam int BYTE_W = 8;
   localparam int LEN_W  = 2 * BYTE_W;

   if (DIV_W < 1 || DIV_W > LEN_W) begin : g_bad_div
      $error("DIV_W must lie in 1..16");
   end
   if (PRESCALE < 2) begin : g_bad_pre
      $error("PRESCALE must be at least 2");
   end

   state_t            state_q;
   logic [7:0]        op_q, arg_lo_q, val_q, dir_q, rx_q, bad_q;
   logic [LEN_W-1:0]  remain_q;
   logic [DIV_W-1:0]  div_q;
   logic              pre_en_q, loop_q;
   logic [LEN_W-1:0]  arg_full;

   logic              tick, sh_start, sh_busy, sh_sck, sh_mosi, sh_done, sh_miso;
   logic [7:0]        sh_tx, sh_rx;
   logic              in_fire, out_fire;

   assign arg_full = {in_data, arg_lo_q};
   assign in_ready = (state_q == S_IDLE) || (state_q == S_ARG_A) ||
                     (state_q == S_ARG_B) || (state_q == S_WR);
   assign in_fire  = in_valid && in_ready;
   assign out_valid = (state_q == S_RD_PUSH) || (state_q == S_ERR_A) ||
                      (state_q == S_ERR_B);
   assign out_fire = out_valid && out_ready;

   always_comb begin
      unique case (state_q)
         S_ERR_A: out_data = ERR_TAG;
         S_ERR_B: out_data = bad_q;
         default: out_data = rx_q;
      endcase
   end

   assign sh_start = (state_q == S_WR && in_valid) || (state_q == S_RD);
   assign sh_tx    = (state_q == S_WR) ? in_data : 8'h00;

   generate
      if (LOOPBACK_EN) begin : g_loop
         assign sh_miso = loop_q ? sh_mosi : miso;
      end else begin : g_noloop
         assign sh_miso = miso;
      end
   endgenerate

   spb_clkgen #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(sh_busy), .pre_en(pre_en_q),
      .div(div_q), .tick(tick)
   );

   spb_shifter #(.W(BYTE_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .tick(tick),
      .miso(sh_miso), .busy(sh_busy), .sck(sh_sck), .mosi(sh_mosi),
      .done(sh_done), .rx(sh_rx)
   );

   assign pin_out = {val_q[7:2],
                     sh_busy ? sh_mosi : val_q[1],
                     sh_busy ? sh_sck  : val_q[0]};
   assign pin_oe  = dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         op_q     <= '0;
         arg_lo_q <= '0;
         val_q    <= '0;
         dir_q    <= '0;
         rx_q     <= '0;
         bad_q    <= '0;
         remain_q <= '0;
         div_q    <= '0;
         pre_en_q <= 1'b1;
         loop_q   <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: if (in_fire) begin
               unique case (in_data)
                  OP_LOOP_ON:  loop_q   <= 1'b1;
                  OP_LOOP_OFF: loop_q   <= 1'b0;
                  OP_PRE_OFF:  pre_en_q <= 1'b0;
                  OP_PRE_ON:   pre_en_q <= 1'b1;
                  OP_DIV, OP_PINS, OP_WRITE, OP_READ: begin
                     op_q    <= in_data;
                     state_q <= S_ARG_A;
                  end
                  default: begin
                     bad_q   <= in_data;
                     state_q <= S_ERR_A;
                  end
               endcase
            end
            S_ARG_A: if (in_fire) begin
               arg_lo_q <= in_data;
               state_q  <= S_ARG_B;
            end
            S_ARG_B: if (in_fire) begin
               state_q <= S_IDLE;
               unique case (op_q)
                  OP_DIV:   div_q <= arg_full[DIV_W-1:0];
                  OP_PINS: begin
                     val_q <= arg_lo_q;
                     dir_q <= in_data;
                  end
                  OP_WRITE: begin
                     remain_q <= arg_full;
                     state_q  <= S_WR;
                  end
                  default: begin
                     remain_q <= arg_full;
                     state_q  <= S_RD;
                  end
               endcase
            end
            S_WR: if (in_fire) state_q <= S_WR_SH;
            S_WR_SH: if (sh_done) begin
               if (remain_q == '0) state_q <= S_IDLE;
               else begin
                  remain_q <= remain_q - 1'b1;
                  state_q  <= S_WR;
               end
            end
            S_RD: state_q <= S_RD_SH;
            S_RD_SH: if (sh_done) begin
               rx_q    <= sh_rx;
               state_q <= S_RD_PUSH;
            end
            S_RD_PUSH: if (out_fire) begin
               if (remain_q == '0) state_q <= S_IDLE;
               else begin
                  remain_q <= remain_q - 1'b1;
                  state_q  <= S_RD;
               end
            end
            S_ERR_A: if (out_fire) state_q <= S_ERR_B;
            S_ERR_B: if (out_fire) state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spb_checker.sv
module spb_checker (
   input logic            clk,
   input logic            rst_n,
   input logic            in_ready,
   input logic            out_valid,
   input logic [7:0]      out_data,
   input logic            out_ready,
   input logic            sh_busy,
   input logic            sh_sck,
   input logic            sh_mosi,
   input logic            tick,
   input spb_pkg::state_t state
);
   import spb_pkg::*;

   a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> !in_ready);

   a_r3_mosi_steady_rise: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy && $past(sh_busy) && $rose(sh_sck) |-> $stable(sh_mosi));

   a_r3_sck_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_busy |-> !sh_sck);

   a_r6_sck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy && $past(sh_busy) && !$past(tick) |-> $stable(sh_sck));

   a_r8_err_pair: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_ERR_A && out_ready |=> out_valid && state == S_ERR_B);
endmodule

bind spi_byte_engine spb_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
   .out_data(out_data), .out_ready(out_ready), .sh_busy(sh_busy),
   .sh_sck(sh_sck), .sh_mosi(sh_mosi), .tick(tick), .state(state_q)
);

// File: tb/sim_spi_byte_engine.sv
module sim_spi_byte_engine;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n, in_valid, in_ready, out_valid, out_ready, miso_m;
   logic [7:0] in_data, out_data, pin_out, pin_oe;

   spi_byte_engine u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready), .miso(miso_m), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   int errs = 0, checks = 0;
   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // slave model: counts SCK edges, captures MOSI, returns a pattern on MISO
   int rise_cnt = 0, last_period = 0, slave_bits = 0;
   longint prev_rise = 0;
   bit have_prev = 0;
   logic [7:0] cap_sh = 0;
   logic [7:0] wr_cap [0:299];
   logic [7:0] cur_pat;
   wire sck_w = pin_out[0];

   function automatic logic [7:0] pat(int k);
      return 8'(k * 29 + 7);
   endfunction
   function automatic logic [7:0] wpat(int k, int s);
      return 8'(k * 53 + s * 17 + 3);
   endfunction

   always_comb begin
      cur_pat = pat(slave_bits / 8);
      miso_m  = cur_pat[7 - (slave_bits % 8)];
   end

   always @(posedge sck_w) begin
      if (have_prev) last_period = int'(cyc - prev_rise);
      prev_rise = cyc;
      have_prev = 1;
      cap_sh = {cap_sh[6:0], pin_out[1]};
      rise_cnt++;
      if (rise_cnt % 8 == 0 && rise_cnt / 8 <= 300) wr_cap[rise_cnt/8 - 1] = cap_sh;
   end
   always @(negedge sck_w) slave_bits++;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic recv(output logic [7:0] b);
      @(negedge clk);
      out_ready = 1'b1;
      while (!out_valid) @(negedge clk);
      b = out_data;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_mon();
      rise_cnt = 0; have_prev = 0; slave_bits = 0; last_period = 0;
   endtask

   task automatic write_block(int n, int s, string req);
      clear_mon();
      send(8'h11); send(8'((n - 1) & 255)); send(8'((n - 1) >> 8));
      for (int i = 0; i < n; i++) send(wpat(i, s));
      wait_idle();
      chk({req, " edge count"}, rise_cnt, 8 * n);
      for (int i = 0; i < n && i < 300; i++)
         chk({req, " mosi byte"}, int'(wr_cap[i]), int'(wpat(i, s)));
   endtask

   task automatic read_block(int n, bit loop, string req);
      logic [7:0] b;
      clear_mon();
      send(8'h20); send(8'((n - 1) & 255)); send(8'((n - 1) >> 8));
      for (int i = 0; i < n; i++) begin
         recv(b);
         chk(req, int'(b), loop ? 0 : int'(pat(i)));
      end
      wait_idle();
   endtask

   task automatic pins(logic [7:0] v, logic [7:0] d);
      send(8'h80); send(v); send(d); wait_idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [7:0] b, d0;
      rst_n = 0; in_valid = 0; in_data = 0; out_ready = 0;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 pin_out", int'(pin_out), 0);
      chk("R1 pin_oe", int'(pin_oe), 0);
      chk("R1 in_ready", int'(in_ready), 1);
      chk("R1 out_valid", int'(out_valid), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2 pin writes
      pins(8'h08, 8'h0B);
      chk("R2 value", int'(pin_out), 8'h08);
      chk("R2 dir", int'(pin_oe), 8'h0B);
      pins(8'hA4, 8'hF0);
      chk("R2 value", int'(pin_out), 8'hA4);
      chk("R2 dir", int'(pin_oe), 8'hF0);
      pins(8'h00, 8'h0B);
      chk("R2 cs low", int'(pin_out[3]), 0);

      // R1 default rate, R3 single byte
      write_block(1, 0, "R3");
      chk("R1 default period", last_period, 10);
      chk("R3 sck low after", int'(pin_out[0]), 0);

      // R6 prescaler off, divisor sweep
      send(8'h8A);
      for (int d = 0; d < 4; d++) begin
         send(8'h86); send(8'(d)); send(8'h00);
         write_block(2, d + 1, "R3");
         chk("R6 period pre off", last_period, 2 * (d + 1));
      end
      send(8'h86); send(8'h00); send(8'h01);
      write_block(1, 9, "R3");
      chk("R6 period high divisor byte", last_period, 2 * 257);
      send(8'h8B); send(8'h86); send(8'h01); send(8'h00);
      write_block(1, 7, "R3");
      chk("R6 period pre on", last_period, 20);

      // R5 long block with non-zero high count byte
      send(8'h8A); send(8'h86); send(8'h00); send(8'h00);
      write_block(257, 5, "R5");
      write_block(3, 11, "R5");

      // R4 read from slave, R9 hold under back-pressure
      read_block(2, 0, "R4");
      clear_mon();
      send(8'h20); send(8'h02); send(8'h00);
      recv(b); chk("R4 byte0", int'(b), int'(pat(0)));
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      d0 = out_data;
      repeat (6) @(negedge clk);
      chk("R9 valid held", int'(out_valid), 1);
      chk("R9 data held", int'(out_data), int'(d0));
      chk("R9 no extra edges", rise_cnt, 16);
      recv(b); chk("R4 byte1", int'(b), int'(pat(1)));
      recv(b); chk("R4 byte2", int'(b), int'(pat(2)));
      wait_idle();

      // R7 loopback on and off
      send(8'h84);
      read_block(2, 1, "R7 loop on");
      send(8'h85);
      read_block(2, 0, "R7 loop off");

      // R8 unknown opcodes
      foreach (d0[i]) begin end
      for (int k = 0; k < 4; k++) begin
         logic [7:0] bad;
         bad = (k == 0) ? 8'h00 : (k == 1) ? 8'h42 : (k == 2) ? 8'hFF : 8'h87;
         send(bad);
         recv(b); chk("R8 tag", int'(b), 8'hFA);
         recv(b); chk("R8 echo", int'(b), int'(bad));
         wait_idle();
         chk("R8 idle after", int'(out_valid), 0);
      end
      pins(8'h5A, 8'h3C);
      chk("R8 decode resumes", int'(pin_out), 8'h5A);
      chk("R8 decode resumes dir", int'(pin_oe), 8'h3C);

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule